// File: doc/BRIEF.md
# Multi-User Hardware Mailbox

This block lets up to four processors pass short 32-bit messages to one another through a set of small hardware queues. All access is over a simple single-cycle register bus. A write to a queue's message register puts a word in that queue, and a read takes the oldest word out. Each queue also has a read-only message count and a status register that shows it is full and records when a write was dropped.

Every user has its own interrupt line and its own bank of event registers. Each queue raises two events:

- "holds a message", meaning the queue is not empty.
- "has space", meaning the queue is not full.

Events are latched per user. A user attaches or detaches a queue event through write-one-to-set and write-one-to-clear enable registers. Its interrupt line is raised only by the latched events it has enabled. Routing these lines to particular processors is done outside the block.

The register map uses word addresses on `addr_i[7:4]` (page) and `addr_i[3:0]` (index):

| Page | Index | Register |
|---|---|---|
| 0 | q | queue message |
| 1 | q | queue count |
| 2 | q | queue status |
| 3 | 4u+k | per-user registers |

For the per-user page, k selects the register: 0 raw status, 1 masked status, 2 enable set, 3 enable clear.

Top module: `mbox_top`

## Requirements
- R1: On reset every queue is emptied (count 0), all enables and latched events are cleared, and every `irq_o` bit is low. Two cycles after reset, the raw status of each user reads only the "has space" bits (0xAA with four queues).
- R2: A write to address 0x00+q appends the word to queue q. Reads of 0x00+q return words oldest first. Address 0x10+q reads the number of stored words, from 0 to 4.
- R3: When queue q holds 4 words, bit 0 of the status register at 0x20+q is 1. A further write to that queue is dropped and leaves its contents and count unchanged.
- R4: A dropped write sets bit 1 of 0x20+q. That bit stays set, even after the queue drains, until software writes 1 to bit 1 of that register or reset is asserted.
- R5: A read of an empty queue returns 0 and leaves its count at 0.
- R6: Each user's event vector uses bit 2q for "queue q not empty" and bit 2q+1 for "queue q not full". The raw status at 0x30+4u latches each event while its condition holds, whatever the enables.
- R7: Writing 1s to 0x32+4u sets those enable bits, and writing 1s to 0x33+4u clears them. Writing 0 bits has no effect. Both addresses read back the current enable mask.
- R8: 0x31+4u reads raw status AND enable. Writing 1s there clears those latched bits for that user only. A read issued in the very next cycle sees them cleared. If the condition still holds, the bit is latched again one cycle after the clear.
- R9: `irq_o[u]` is the registered OR of (raw AND enable) for user u. It rises two clock edges after the edge that accepts the write creating the event. It is low in any cycle that follows one in which that user has no enables.
- R10: A user's interrupt and masked status ignore events that only other users have enabled.
- R11: `rdata_o` and `rvalid_o` are valid one cycle after a read request. Addresses that decode to no register read 0.
- R12: A "not full" event whose latched bit is cleared while the queue is full stays low. It re-asserts one cycle after a read frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | AW (8) | Word address: page in [7:4], index in [3:0] |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | NUM_U (4) | Interrupt line per user |

## Verification
A queue pointer or count that has gone wrong shows up as soon as the queue is read: the words come back out of order, or the count register disagrees with the number of accepted writes. A latched-event or enable bit that has gone wrong shows on the affected user's `irq_o` within two edges, and it shows on the raw and masked status reads at once. A clear that reaches the wrong user shows up as changed status on a user that was never written. The bench therefore reads back every register it touches and times interrupt edges to the exact cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [3:0] PAGE_MSG = 4'd0;
  localparam logic [3:0] PAGE_CNT = 4'd1;
  localparam logic [3:0] PAGE_QST = 4'd2;
  localparam logic [3:0] PAGE_USR = 4'd3;

  typedef enum logic [1:0] {
    UREG_RAW    = 2'd0,
    UREG_MASKED = 2'd1,
    UREG_EN_SET = 2'd2,
    UREG_EN_CLR = 2'd3
  } ureg_e;

  localparam int unsigned QST_FULL_BIT = 0;
  localparam int unsigned QST_OVF_BIT  = 1;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic          ovf_clr_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_ptr_q] <= wdata_i;
        wr_ptr_q        <= nxt(wr_ptr_q);
      end
      if (do_pop) rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // dropped write wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_q <= 1'b0;
    else if (push_i && full_o)   ovf_q <= 1'b1;
    else if (ovf_clr_i)          ovf_q <= 1'b0;
  end

  assign head_o  = empty_o ? '0 : mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int unsigned NEV = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] cond_i,
  input  logic [NEV-1:0] wmask_i,
  input  logic           en_set_i,
  input  logic           en_clr_i,
  input  logic           st_clr_i,
  output logic [NEV-1:0] raw_o,
  output logic [NEV-1:0] en_o,
  output logic           irq_o
);
  logic [NEV-1:0] raw_q, en_q;
  logic           irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (en_set_i) en_q <= en_q | wmask_i;
    else if (en_clr_i) en_q <= en_q & ~wmask_i;
  end

  // cleared bits drop for one cycle, then relatch if the condition persists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       raw_q <= '0;
    else if (st_clr_i) raw_q <= (raw_q | cond_i) & ~wmask_i;
    else               raw_q <= raw_q | cond_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(raw_q & en_q);
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned NUM_U = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic [NUM_U-1:0] irq_o
);
  localparam int unsigned NEV = 2 * NUM_Q;
  localparam int unsigned CW  = $clog2(DEPTH + 1);

  logic [3:0] page, idx;
  logic       wr_req, rd_req;

  assign page   = addr_i[7:4];
  assign idx    = addr_i[3:0];
  assign wr_req = req_i & we_i;
  assign rd_req = req_i & ~we_i;

  logic [DW-1:0]       head   [NUM_Q];
  logic [CW-1:0]       cnt    [NUM_Q];
  logic [NUM_Q-1:0]    push_v, pop_v, ovf_clr_v, full_v, empty_v, ovf_v;
  logic [NEV-1:0]      ev_cond;
  logic [NUM_Q*CW-1:0] cnt_flat;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic hit;
    assign hit          = (idx == 4'(q));
    assign push_v[q]    = wr_req & (page == PAGE_MSG) & hit;
    assign pop_v[q]     = rd_req & (page == PAGE_MSG) & hit;
    assign ovf_clr_v[q] = wr_req & (page == PAGE_QST) & hit & wdata_i[QST_OVF_BIT];

    mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push_v[q]),
      .wdata_i   (wdata_i),
      .pop_i     (pop_v[q]),
      .ovf_clr_i (ovf_clr_v[q]),
      .head_o    (head[q]),
      .count_o   (cnt[q]),
      .full_o    (full_v[q]),
      .empty_o   (empty_v[q]),
      .ovf_o     (ovf_v[q])
    );

    assign ev_cond[2*q]         = ~empty_v[q];
    assign ev_cond[2*q+1]       = ~full_v[q];
    assign cnt_flat[q*CW +: CW] = cnt[q];
  end

  logic [NEV-1:0]       raw [NUM_U];
  logic [NEV-1:0]       en  [NUM_U];
  logic [NUM_U*NEV-1:0] raw_flat, en_flat, en_clr_v, st_clr_v;
  ureg_e                ukind;

  assign ukind = ureg_e'(idx[1:0]);

  for (genvar u = 0; u < NUM_U; u++) begin : g_u
    logic sel, set_we, clr_we, stc_we;
    assign sel    = wr_req & (page == PAGE_USR) & (idx[3:2] == 2'(u));
    assign set_we = sel & (ukind == UREG_EN_SET);
    assign clr_we = sel & (ukind == UREG_EN_CLR);
    assign stc_we = sel & (ukind == UREG_MASKED);

    mbox_user_irq #(.NEV(NEV)) user_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cond_i   (ev_cond),
      .wmask_i  (wdata_i[NEV-1:0]),
      .en_set_i (set_we),
      .en_clr_i (clr_we),
      .st_clr_i (stc_we),
      .raw_o    (raw[u]),
      .en_o     (en[u]),
      .irq_o    (irq_o[u])
    );

    assign raw_flat[u*NEV +: NEV] = raw[u];
    assign en_flat[u*NEV +: NEV]  = en[u];
    assign en_clr_v[u*NEV +: NEV] = {NEV{clr_we}} & wdata_i[NEV-1:0];
    assign st_clr_v[u*NEV +: NEV] = {NEV{stc_we}} & wdata_i[NEV-1:0];
  end

  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    unique case (page)
      PAGE_MSG: for (int q = 0; q < int'(NUM_Q); q++)
                  if (idx == 4'(q)) rd_val = head[q];
      PAGE_CNT: for (int q = 0; q < int'(NUM_Q); q++)
                  if (idx == 4'(q)) rd_val = DW'(cnt[q]);
      PAGE_QST: for (int q = 0; q < int'(NUM_Q); q++)
                  if (idx == 4'(q)) begin
                    rd_val[QST_FULL_BIT] = full_v[q];
                    rd_val[QST_OVF_BIT]  = ovf_v[q];
                  end
      PAGE_USR: for (int u = 0; u < int'(NUM_U); u++)
                  if (idx[3:2] == 2'(u)) begin
                    case (ukind)
                      UREG_RAW:    rd_val = DW'(raw[u]);
                      UREG_MASKED: rd_val = DW'(raw[u] & en[u]);
                      default:     rd_val = DW'(en[u]);
                    endcase
                  end
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_val;
    end
  end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned NUM_U = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3,
  parameter int unsigned NEV   = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_Q-1:0]     push_v,
  input logic [NUM_Q-1:0]     pop_v,
  input logic [NUM_Q-1:0]     full_v,
  input logic [NUM_Q-1:0]     empty_v,
  input logic [NUM_Q-1:0]     ovf_v,
  input logic [NUM_Q*CW-1:0]  cnt_flat,
  input logic [NUM_U*NEV-1:0] en_flat,
  input logic [NUM_U*NEV-1:0] raw_flat,
  input logic [NUM_U*NEV-1:0] en_clr_v,
  input logic [NUM_U*NEV-1:0] st_clr_v,
  input logic [NUM_U-1:0]     irq_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    // R2
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_flat[q*CW +: CW] <= DEPTH_C);
    // R3
    full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_v[q] && full_v[q] && !pop_v[q]) |=> $stable(cnt_flat[q*CW +: CW]));
    // R5
    empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_v[q] && empty_v[q] && !push_v[q]) |=> (cnt_flat[q*CW +: CW] == '0));
    // R4
    ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_v[q]) |-> $past(push_v[q] && full_v[q]));
  end

  // R7
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_v != '0) |=> ((en_flat & $past(en_clr_v)) == '0));
  // R8
  st_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_clr_v != '0) |=> ((raw_flat & $past(st_clr_v)) == '0));

  for (genvar u = 0; u < NUM_U; u++) begin : g_u
    // R9
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_flat[u*NEV +: NEV] == '0) |=> !irq_o[u]);
  end
endmodule

bind mbox_top mbox_chk #(
  .NUM_Q(NUM_Q), .NUM_U(NUM_U), .DEPTH(DEPTH), .CW(CW), .NEV(NEV)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .push_v   (push_v),
  .pop_v    (pop_v),
  .full_v   (full_v),
  .empty_v  (empty_v),
  .ovf_v    (ovf_v),
  .cnt_flat (cnt_flat),
  .en_flat  (en_flat),
  .raw_flat (raw_flat),
  .en_clr_v (en_clr_v),
  .st_clr_v (st_clr_v),
  .irq_o    (irq_o)
);

// File: tb/mbox_top_tb.sv
module mbox_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_i, we_i;
  logic [7:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [3:0]  irq_o;

  always #5 clk_i = ~clk_i;

  mbox_top dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .irq_o    (irq_o)
  );

  typedef struct {
    logic [31:0] exp;
    logic [7:0]  addr;
    string       tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.addr = a; it.tag = tag;
    sb.push_back(it);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: compare read results against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (sb.size() == 0) chk(1'b0, "R11 unexpected read data", rdata_o, 32'h0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(rdata_o == it.exp, $sformatf("%s @0x%0h", it.tag, it.addr), rdata_o, it.exp);
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    chk(irq_o == 4'h0, "R1 irq low after reset", 32'(irq_o), 32'h0);
    rd(8'h30, 32'hAA, "R1 raw status after reset");
    rd(8'h10, 32'h0,  "R1 count after reset");
    rd(8'h32, 32'h0,  "R1 enables after reset");

    // R2 FIFO order and count
    wr(8'h00, 32'h11); wr(8'h00, 32'h22); wr(8'h00, 32'h33);
    rd(8'h10, 32'h3,  "R2 count after three writes");
    rd(8'h00, 32'h11, "R2 oldest first");
    rd(8'h00, 32'h22, "R2 second");
    rd(8'h00, 32'h33, "R2 third");
    rd(8'h10, 32'h0,  "R2 count drained");

    // R5 empty read
    rd(8'h00, 32'h0, "R5 empty read returns zero");
    rd(8'h10, 32'h0, "R5 count stays zero");

    // R3 / R4 full, dropped write, sticky overflow
    for (int i = 0; i < 5; i++) wr(8'h01, 32'h100 + 32'(i));
    rd(8'h11, 32'h4, "R3 count at full");
    rd(8'h21, 32'h3, "R3 full and R4 overflow bits");
    for (int i = 0; i < 4; i++) rd(8'h01, 32'h100 + 32'(i), "R3 dropped word absent");
    rd(8'h21, 32'h2, "R4 overflow sticky after drain");
    wr(8'h21, 32'h2);
    rd(8'h21, 32'h0, "R4 overflow cleared");

    // clear latched history for all users
    wr(8'h31, 32'hFF); wr(8'h35, 32'hFF); wr(8'h39, 32'hFF); wr(8'h3D, 32'hFF);
    idle(1);
    rd(8'h34, 32'hAA, "R6 raw relatches only space events");

    // R7 enable set, zero write ignored, readback on both
    wr(8'h36, 32'h01);
    wr(8'h36, 32'h00);
    rd(8'h36, 32'h01, "R7 set register readback");
    rd(8'h37, 32'h01, "R7 clear register readback");
    chk(irq_o[1] == 1'b0, "R9 no irq without event", 32'(irq_o[1]), 32'h0);

    // R9 timing: two edges after the write
    wr(8'h00, 32'h55);
    chk(irq_o[1] == 1'b0, "R9 irq not after first edge", 32'(irq_o[1]), 32'h0);
    idle(1);
    chk(irq_o[1] == 1'b0, "R9 irq not after second edge", 32'(irq_o[1]), 32'h0);
    idle(1);
    chk(irq_o[1] == 1'b1, "R9 irq after third edge", 32'(irq_o[1]), 32'h1);
    chk(irq_o[0] == 1'b0 && irq_o[3] == 1'b0, "R10 other users quiet", 32'(irq_o), 32'h2);
    rd(8'h35, 32'h01, "R8 masked status user1");
    rd(8'h31, 32'h00, "R10 masked status user0");

    // R8 clear with condition still true
    wr(8'h35, 32'h01);
    rd(8'h34, 32'hAA, "R8 cleared bit reads zero next cycle");
    rd(8'h34, 32'hAB, "R8 bit relatched");
    rd(8'h30, 32'hAB, "R8 other user untouched");

    // R7 enable clear
    wr(8'h37, 32'h01);
    rd(8'h36, 32'h00, "R7 enable cleared");
    chk(irq_o[1] == 1'b0, "R9 irq drops after disable", 32'(irq_o[1]), 32'h0);
    rd(8'h35, 32'h00, "R8 masked status after disable");

    // R12 not-full event
    wr(8'h3A, 32'h08);
    idle(1);
    chk(irq_o[2] == 1'b1, "R12 space event irq", 32'(irq_o[2]), 32'h1);
    for (int i = 0; i < 4; i++) wr(8'h01, 32'h200 + 32'(i));
    wr(8'h39, 32'h08);
    idle(2);
    chk(irq_o[2] == 1'b0, "R12 no relatch while full", 32'(irq_o[2]), 32'h0);
    rd(8'h38, 32'hA7, "R12 raw bit3 low while full");
    rd(8'h01, 32'h200, "R12 pop frees entry");
    idle(2);
    chk(irq_o[2] == 1'b1, "R12 reassert after pop", 32'(irq_o[2]), 32'h1);

    // R11 unmapped
    rd(8'h7F, 32'h0, "R11 unmapped page");
    rd(8'h05, 32'h0, "R11 queue index out of range");
    idle(2);

    // R1 reset mid-operation
    rst_ni = 1'b0;
    idle(1);
    rst_ni = 1'b1;
    idle(2);
    chk(irq_o == 4'h0, "R1 irq low after second reset", 32'(irq_o), 32'h0);
    rd(8'h10, 32'h0,  "R1 queue0 emptied");
    rd(8'h11, 32'h0,  "R1 queue1 emptied");
    rd(8'h3A, 32'h0,  "R1 user2 enables cleared");
    rd(8'h38, 32'hAA, "R1 user2 raw reset");

    idle(3);
    chk(sb.size() == 0, "R11 every read answered", 32'(sb.size()), 32'h0);
    finish_run();
  end
endmodule